// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

This block is a 32-pin general-purpose I/O port on a simple word-wide register bus. Each pin is either an input or an output. Output pins are driven from a stored data word. Input levels pass through a two-flop synchronizer and can be read back as a pad-level word.

Every pin also has its own interrupt detector. Each pin can be set to low level, high level, rising edge, falling edge or any edge. A detected condition sets a sticky per-pin status bit, and software clears that bit by writing 1 to it. A mask word selects which status bits reach the single registered interrupt line. Software polls or services the port through eight word registers in a 0x20-byte window.

Top module: `gpio_irq_port`

## Requirements
- R1: After a synchronous active-low reset, all pins are inputs (`pad_oe` = 0), `pad_out` = 0, `irq` = 0, and the data, direction, sense, mask and any-edge registers read 0.
- R2: The direction word sits at byte offset 0x04. A bit of 1 asserts the matching `pad_oe` bit, which makes the pin an output. `pad_out` carries the data word at all times.
- R3: The word at offset 0x08 returns the pad levels after two synchronizer flops: a change on `pad_in` shows in a read two clock edges later. Writes to this offset change nothing.
- R4: The sense code of pin n is held in bits [2(n mod 16)+1 : 2(n mod 16)]. For pins 0–15 that is the word at 0x0C, and for pins 16–31 the word at 0x10. The codes are 00 low level, 01 high level, 10 rising edge and 11 falling edge.
- R5: A pin with a level code sets its status bit on every cycle its synchronized level matches. A clear therefore has no lasting effect while the level holds.
- R6: Edge codes compare the synchronized level with its value one cycle earlier. The status bit sets on the edge edge after the level has passed both synchronizer flops, which is three edges after the pad change.
- R7: A 1 in the any-edge word (offset 0x1C) makes its pin detect both rising and falling edges, and the sense code of that pin is ignored.
- R8: The status word (offset 0x18) is sticky. Writing 1 to a bit clears it, and writing 0 has no effect. An event in the same cycle as a clear keeps the bit set.
- R9: The mask word is at offset 0x14. Status bits set whatever the mask holds. `irq` is the OR of (status AND mask), registered, so it follows one edge after the status bit.
- R10: The data word is at offset 0x00, and reading it returns the stored value, not the pad level.
- R11: Writes take effect only when `bus_sel` and `bus_wr` are high and `bus_addr[1:0]` = 0. `bus_rdata` always shows the word selected by `bus_addr[4:2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output level per pin |
| pad_oe | output | 32 | Output enable per pin |
| irq | output | 1 | Combined registered interrupt |

## Verification
The hardest case to reach is a clear write that arrives on the exact edge at which an edge event sets the same status bit. The write must line up with the third clock edge after the pad change, so that the event and the clear collide. The bench changes the pad, waits exactly two edges, and then issues the clear, so the write is sampled on the colliding edge. A behavioural reference model, stepped on every clock edge, confirms that the bit survives. The same model is compared with `irq`, `pad_out`, `pad_oe` and the addressed read word on every cycle, so the level re-set after a clear and the any-edge override are checked cycle by cycle as well.

// File: rtl/gpio_pkg.sv
// Package: shared word indices and sense codes for the GPIO port.
// Assumes a 32-bit word bus with byte addresses, so the word index is addr[4:2].
package gpio_pkg;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 5;

    localparam logic [2:0] IDX_DATA   = 3'd0;
    localparam logic [2:0] IDX_DIR    = 3'd1;
    localparam logic [2:0] IDX_LEVEL  = 3'd2;
    localparam logic [2:0] IDX_SENSE0 = 3'd3;
    localparam logic [2:0] IDX_SENSE1 = 3'd4;
    localparam logic [2:0] IDX_MASK   = 3'd5;
    localparam logic [2:0] IDX_STATUS = 3'd6;
    localparam logic [2:0] IDX_ANYEDG = 3'd7;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_HIGH = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_FALL = 2'b11
    } sense_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: gpio_in_sync
// Brings asynchronous pad levels into the clock domain through a STAGES-deep
// flop chain. It also keeps the synchronized level from one cycle earlier,
// which the edge detectors use.
// Assumes STAGES >= 2 and a synchronous active-low reset.
module gpio_in_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic [W-1:0] level_prev
);
    logic [STAGES-1:0][W-1:0] chain_q;
    logic [W-1:0]             prev_q;

    // Shift the pad sample along the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    // Keep the synchronized level from one cycle back.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level      = chain_q[STAGES-1];
    assign level_prev = prev_q;
endmodule

// File: rtl/gpio_event_detect.sv
// Module: gpio_event_detect
// Combinational per-pin condition detector. Each pin uses its 2-bit sense
// code, unless its any-edge bit is set, in which case both edges count.
// Assumes the inputs are already synchronized.
module gpio_event_detect
    import gpio_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   prev,
    input  logic [2*W-1:0] sense,
    input  logic [W-1:0]   any_edge,
    output logic [W-1:0]   evt
);
    for (genvar p = 0; p < W; p++) begin : g_pin
        sense_e code;
        assign code = sense_e'(sense[2*p +: 2]);

        // Decide whether pin p shows its configured condition this cycle.
        always_comb begin
            if (any_edge[p]) begin
                evt[p] = cur[p] ^ prev[p];
            end else begin
                unique case (code)
                    SENSE_LOW:  evt[p] = ~cur[p];
                    SENSE_HIGH: evt[p] = cur[p];
                    SENSE_RISE: evt[p] = cur[p] & ~prev[p];
                    SENSE_FALL: evt[p] = ~cur[p] & prev[p];
                    default:    evt[p] = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_status_bank.sv
// Module: gpio_status_bank
// Holds the sticky per-pin status bits. A clear is write-1-to-clear, and a
// set in the same cycle takes priority. Also registers the masked OR as the
// interrupt line.
// Assumes clr is already qualified by a valid write strobe.
module gpio_status_bank #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] mask,
    output logic [W-1:0] status,
    output logic         irq
);
    logic [W-1:0] status_q;
    logic         irq_q;

    // Update the sticky status: clear first, then the new events win.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr) | evt;
    end

    // Register the combined masked interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status_q & mask);
    end

    assign status = status_q;
    assign irq    = irq_q;
endmodule

// File: rtl/gpio_irq_port.sv
// Module: gpio_irq_port (top)
// 32-pin I/O port with a word register bus and per-pin interrupt detection.
// Contains the register decode and the read mux, and instantiates the
// synchronizer, the event detectors and the status bank.
// Assumes single-cycle accesses: a write lands on the next edge, and reads
// are combinational from the addressed word.
module gpio_irq_port
    import gpio_pkg::*;
#(
    parameter int unsigned PIN_W       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pad_in,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pad_oe,
    output logic              irq
);
    localparam int unsigned SENSE_W = 2 * PIN_W;

    logic [PIN_W-1:0] data_q, dir_q, sense0_q, sense1_q, mask_q, anyedge_q;
    logic [PIN_W-1:0] level, level_prev, evt, status_q, clr;
    logic [SENSE_W-1:0] sense_flat;
    logic [2:0] widx;
    logic       wr_ok;

    assign widx  = bus_addr[4:2];
    assign wr_ok = bus_sel & bus_wr & (bus_addr[1:0] == 2'b00);

    // Store the writable configuration and data words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q    <= '0;
            dir_q     <= '0;
            sense0_q  <= '0;
            sense1_q  <= '0;
            mask_q    <= '0;
            anyedge_q <= '0;
        end else if (wr_ok) begin
            case (widx)
                IDX_DATA:   data_q    <= bus_wdata;
                IDX_DIR:    dir_q     <= bus_wdata;
                IDX_SENSE0: sense0_q  <= bus_wdata;
                IDX_SENSE1: sense1_q  <= bus_wdata;
                IDX_MASK:   mask_q    <= bus_wdata;
                IDX_ANYEDG: anyedge_q <= bus_wdata;
                default:    ;
            endcase
        end
    end

    // Form the write-1-to-clear vector for the status bank.
    always_comb begin
        clr = '0;
        if (wr_ok && widx == IDX_STATUS) clr = bus_wdata;
    end

    // Select the addressed word for reading.
    always_comb begin
        unique case (widx)
            IDX_DATA:   bus_rdata = data_q;
            IDX_DIR:    bus_rdata = dir_q;
            IDX_LEVEL:  bus_rdata = level;
            IDX_SENSE0: bus_rdata = sense0_q;
            IDX_SENSE1: bus_rdata = sense1_q;
            IDX_MASK:   bus_rdata = mask_q;
            IDX_STATUS: bus_rdata = status_q;
            IDX_ANYEDG: bus_rdata = anyedge_q;
            default:    bus_rdata = '0;
        endcase
    end

    assign sense_flat = {sense1_q, sense0_q};
    assign pad_out    = data_q;
    assign pad_oe     = dir_q;

    gpio_in_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (pad_in),
        .level      (level),
        .level_prev (level_prev)
    );

    gpio_event_detect #(.W(PIN_W)) u_detect (
        .cur      (level),
        .prev     (level_prev),
        .sense    (sense_flat),
        .any_edge (anyedge_q),
        .evt      (evt)
    );

    gpio_status_bank #(.W(PIN_W)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .clr    (clr),
        .mask   (mask_q),
        .status (status_q),
        .irq    (irq)
    );
endmodule

// File: rtl/gpio_irq_port_chk.sv
// Module: gpio_irq_port_chk
// Assertion checker bound into gpio_irq_port. It watches the bus writes, the
// pin outputs, and the status and mask state.
module gpio_irq_port_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_sel,
    input logic         bus_wr,
    input logic [4:0]   bus_addr,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_oe,
    input logic         irq,
    input logic [W-1:0] status_q,
    input logic [W-1:0] mask_q
);
    logic wr_word;
    assign wr_word = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00);

    assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_word && bus_addr[4:2] == 3'd1) |=> (pad_oe == $past(bus_wdata)));

    assert_data_drives_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_word && bus_addr[4:2] == 3'd0) |=> (pad_out == $past(bus_wdata)));

    assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_word && bus_addr[4:2] == 3'd6) |=> ((status_q & $past(status_q)) == $past(status_q)));

    assert_irq_registered_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == (|($past(status_q) & $past(mask_q)))));

    assert_mask_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_word && bus_addr[4:2] == 3'd5) |=> $stable(mask_q));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.W(PIN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .status_q  (status_q),
    .mask_q    (mask_q)
);

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_port dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // Behavioural reference model state
    logic [31:0] m_data = 0, m_dir = 0, m_s0 = 0, m_s1 = 0, m_mask = 0, m_any = 0;
    logic [31:0] m_status = 0, m_sync1 = 0, m_sync2 = 0, m_prev = 0;
    logic        m_irq = 0;

    function automatic bit pin_event(int i);
        int code;
        code = (i < 16) ? int'(m_s0[2*i +: 2]) : int'(m_s1[2*(i-16) +: 2]);
        if (m_any[i]) return m_sync2[i] != m_prev[i];
        case (code)
            0: return m_sync2[i] == 1'b0;
            1: return m_sync2[i] == 1'b1;
            2: return m_sync2[i] && !m_prev[i];
            default: return !m_sync2[i] && m_prev[i];
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] ev;
        bit wok;
        if (!rst_n) begin
            m_data = 0; m_dir = 0; m_s0 = 0; m_s1 = 0; m_mask = 0; m_any = 0;
            m_status = 0; m_sync1 = 0; m_sync2 = 0; m_prev = 0; m_irq = 0;
        end else begin
            ev = 0;
            for (int i = 0; i < 32; i++) ev[i] = pin_event(i);
            m_irq = |(m_status & m_mask);
            wok = bus_sel && bus_wr && bus_addr[1:0] == 2'b00;
            if (wok && bus_addr[4:2] == 3'd6) m_status = m_status & ~bus_wdata;
            m_status = m_status | ev;
            if (wok) begin
                case (bus_addr[4:2])
                    3'd0: m_data = bus_wdata;
                    3'd1: m_dir  = bus_wdata;
                    3'd3: m_s0   = bus_wdata;
                    3'd4: m_s1   = bus_wdata;
                    3'd5: m_mask = bus_wdata;
                    3'd7: m_any  = bus_wdata;
                    default: ;
                endcase
            end
            m_prev = m_sync2; m_sync2 = m_sync1; m_sync1 = pad_in;
        end
    end

    function automatic logic [31:0] m_read(logic [2:0] w);
        case (w)
            3'd0: return m_data;   3'd1: return m_dir;
            3'd2: return m_sync2;  3'd3: return m_s0;
            3'd4: return m_s1;     3'd5: return m_mask;
            3'd6: return m_status; default: return m_any;
        endcase
    endfunction

    function automatic string rtag(logic [2:0] w);
        case (w)
            3'd0: return "R11/R10"; 3'd1: return "R11/R2";
            3'd2: return "R11/R3";  3'd3, 3'd4: return "R11/R4";
            3'd5: return "R11/R9";  3'd6: return "R11/R8";
            default: return "R11/R7";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: wait for the falling edge, compare against the model.
    task automatic step();
        @(negedge clk);
        if (rst_n) begin
            chk("R9 irq", {31'd0, irq}, {31'd0, m_irq});
            chk("R10 pad_out", pad_out, m_data);
            chk("R2 pad_oe", pad_oe, m_dir);
            chk(rtag(bus_addr[4:2]), bus_rdata, m_read(bus_addr[4:2]));
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        step();
        chk(tag, bus_rdata, exp);
        bus_sel = 0;
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        wait_n(3);
        rst_n = 1;
        step();
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 pad_oe", pad_oe, 32'd0);
        chk("R1 pad_out", pad_out, 32'd0);
        rd(5'h14, 32'h0, "R1 mask");
        rd(5'h0C, 32'h0, "R1 sense0");
        rd(5'h18, 32'hFFFF_FFFF, "R5 low level sets all");
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, 32'hFFFF_FFFF, "R5 level re-sets after clear");

        wr(5'h04, 32'h0000_FFFF);
        wr(5'h00, 32'hA5A5_1234);
        chk("R2 pad_oe", pad_oe, 32'h0000_FFFF);
        chk("R2 pad_out", pad_out, 32'hA5A5_1234);
        pad_in = 32'h0F0F_F0F0;
        rd(5'h00, 32'hA5A5_1234, "R10 data readback");
        wait_n(2);
        rd(5'h08, 32'h0F0F_F0F0, "R3 pad level");
        wr(5'h08, 32'h0);
        rd(5'h08, 32'h0F0F_F0F0, "R3 write ignored");

        wr(5'h0C, 32'hAAAA_AAAA);
        wr(5'h10, 32'hAAAA_AAAA);
        pad_in = 32'h0;
        wait_n(4);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, 32'h0, "R6 no rising yet");
        wr(5'h14, 32'h0000_0008);
        pad_in[3] = 1'b1;
        wait_n(4);
        chk("R9 irq from pin 3", {31'd0, irq}, 32'd1);
        rd(5'h18, 32'h0000_0008, "R6 rising pin 3");
        pad_in[9] = 1'b1;
        wait_n(4);
        rd(5'h18, 32'h0000_0208, "R9 unmasked status sets");
        wr(5'h18, 32'h0);
        rd(5'h18, 32'h0000_0208, "R8 write zero no effect");
        wr(5'h18, 32'h0000_0008);
        rd(5'h18, 32'h0000_0200, "R8 write one clears");
        wait_n(2);
        chk("R9 irq drops", {31'd0, irq}, 32'd0);

        pad_in[5] = 1'b1;
        wait_n(2);
        wr(5'h18, 32'h0000_0020);
        rd(5'h18, 32'h0000_0220, "R8 set wins over clear");

        wr(5'h10, 32'hAAAA_ABAA);
        pad_in[20] = 1'b1;
        wait_n(4);
        rd(5'h18, 32'h0000_0220, "R4 falling ignores rise");
        pad_in[20] = 1'b0;
        wait_n(4);
        rd(5'h18, 32'h0010_0220, "R4 falling pin 20");

        wr(5'h1C, 32'h0000_0080);
        wr(5'h18, 32'hFFFF_FFFF);
        pad_in[7] = 1'b1;
        wait_n(4);
        rd(5'h18, 32'h0000_0080, "R7 any edge rise");
        wr(5'h18, 32'h0000_0080);
        pad_in[7] = 1'b0;
        wait_n(4);
        rd(5'h18, 32'h0000_0080, "R7 any edge fall");

        wr(5'h10, 32'h6AAA_ABAA);
        pad_in[31] = 1'b1;
        wait_n(4);
        wr(5'h18, 32'h8000_0000);
        rd(5'h18, 32'h8000_0080, "R5 high level holds");
        wr(5'h14, 32'h8000_0000);
        wait_n(2);
        chk("R9 irq pin 31", {31'd0, irq}, 32'd1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule